// File: doc/BRIEF.md
# Shift-Register Counter with Decoded State Lines

This block is a counter built from a chain of N flip-flops that shift toward the lower index on every enabled rising clock edge. A parameter selects one of three variants. The first is a circulating single-one counter with N states. The second is a complement-feedback (twisted) counter with 2N states. The third is a twisted counter with 2N-1 states, which leaves out the all-ones pattern. Next to the raw stage vector, the block drives a decoded vector that has one line per state. Each decoded line is formed from one stage bit, or from an AND of two stage bits, which may be true or inverted. Downstream logic can therefore react to any single count position without a wide comparator.

The counter has a synchronous reset and a count enable. Stage patterns that cannot occur in the selected sequence can appear after an upset or at power-up. Such a pattern is detected and replaced with the reset pattern on the next clock edge, so the counter cannot lock up outside its cycle.

Top module: `shift_counter`

## Requirements
- R1: In ring mode, the reset pattern has only stage[N-1] set. On each enabled edge, every bit moves one index lower, and stage[0] wraps into stage[N-1]. The cycle has N states.
- R2: When rst is high at a rising edge, the register loads the reset pattern: stage[N-1]=1 with all other bits 0 in ring mode, and all zeros in both twisted modes. Reset takes priority over cnt_en.
- R3: In even twisted mode, stage[N-1] takes the inverse of stage[0] on each enabled edge, while the other bits shift one index lower. The cycle has 2N distinct states.
- R4: In odd twisted mode, stage[N-1] takes NOT stage[1] AND NOT stage[0], while the other bits shift down. The cycle has 2N-1 states, and the all-ones pattern never follows a legal state.
- R5: With cnt_en low and rst low, a legal state and its decoded lines hold.
- R6: State k is the k-th pattern reached from reset on enabled edges, with k=0 being the reset pattern. In that state, dec_o[k] is the high line. In ring mode, dec_o[k] equals stage[N-1-k].
- R7: In every legal state, exactly one dec_o line is high. In the twisted modes, each line is a two-input AND. Line 0 is NOT stage[N-1] AND NOT stage[0]. Line k, for 1 <= k <= N-1, is stage[N-k] AND NOT stage[N-1-k]. In even mode, line N is stage[N-1] AND stage[0]. The remaining lines, at base+j, are NOT stage[N-j] AND stage[N-1-j], where base is N in even mode and N-1 in odd mode.
- R8: Some patterns are illegal. In ring mode, an illegal pattern has zero or several ones. In the twisted modes, an illegal pattern has more than one change between adjacent bits, and in odd mode all ones is also illegal. From any illegal pattern, the next rising edge loads the reset pattern, whatever the value of cnt_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Advance the sequence by one on this edge |
| stage_q | output | N | Raw flip-flop chain, stage[N-1] is the entry stage |
| dec_o | output | NS | One line per state (NS = N, 2N or 2N-1 by mode) |

## Verification
Each of the three variants is built with N = 3, 4 and 5. Every lane is first run with the enable held high for more than two full cycles; this separates a correct modulus from a sequence that is off by one state or that wraps too early. Next, the enable is held low and then gated irregularly, which tells a true hold apart from a counter that advances regardless of the enable. Reset is asserted together with the enable to confirm its priority. Finally, non-contiguous, all-zero and all-ones patterns are injected into the stage register right after a reset. These patterns show whether the lock-up guard, rather than the reset, returns the counter to its starting pattern on the next edge.

// File: rtl/shc_pkg.sv
package shc_pkg;

    typedef enum logic [1:0] {
        SHC_RING       = 2'd0,
        SHC_TWIST_EVEN = 2'd1,
        SHC_TWIST_ODD  = 2'd2
    } shc_mode_e;

    // Number of states in the cycle for a given variant and stage count.
    function automatic int shc_state_count(shc_mode_e mode, int stages);
        case (mode)
            SHC_RING:       return stages;
            SHC_TWIST_EVEN: return 2 * stages;
            default:        return 2 * stages - 1;
        endcase
    endfunction

endpackage

// File: rtl/shc_feedback.sv
// Next pattern of the chain: shift toward index 0, new entry bit at N-1.
module shc_feedback #(
    parameter int                N    = 4,
    parameter shc_pkg::shc_mode_e MODE = shc_pkg::SHC_TWIST_EVEN
) (
    input  logic [N-1:0] cur,
    output logic [N-1:0] nxt
);
    logic entry;

    generate
        if (MODE == shc_pkg::SHC_RING) begin : g_ring
            assign entry = cur[0];
        end else if (MODE == shc_pkg::SHC_TWIST_EVEN) begin : g_even
            assign entry = ~cur[0];
        end else begin : g_odd
            // two-bit feedback drops the all-ones pattern from the cycle
            assign entry = ~cur[1] & ~cur[0];
        end
    endgenerate

    assign nxt = {entry, cur[N-1:1]};
endmodule

// File: rtl/shc_guard.sv
// Flags whether the current chain pattern belongs to the selected cycle.
module shc_guard #(
    parameter int                N    = 4,
    parameter shc_pkg::shc_mode_e MODE = shc_pkg::SHC_TWIST_EVEN
) (
    input  logic [N-1:0] cur,
    output logic         legal
);
    generate
        if (MODE == shc_pkg::SHC_RING) begin : g_ring
            // exactly one set bit
            assign legal = (cur != '0) && ((cur & (cur - 1'b1)) == '0);
        end else begin : g_twist
            logic [N-2:0] edges;
            logic         contiguous;
            assign edges      = cur[N-1:1] ^ cur[N-2:0];
            // at most one boundary between a run of ones and a run of zeros
            assign contiguous = (edges & (edges - 1'b1)) == '0;
            if (MODE == shc_pkg::SHC_TWIST_ODD) begin : g_odd
                assign legal = contiguous && (cur != '1);
            end else begin : g_even
                assign legal = contiguous;
            end
        end
    endgenerate
endmodule

// File: rtl/shc_decode.sv
// One output line per state; each line uses one stage bit or a two-input AND.
module shc_decode #(
    parameter int                N    = 4,
    parameter shc_pkg::shc_mode_e MODE = shc_pkg::SHC_TWIST_EVEN,
    localparam int               NS   = shc_pkg::shc_state_count(MODE, N)
) (
    input  logic [N-1:0]  cur,
    output logic [NS-1:0] dec
);
    generate
        if (MODE == shc_pkg::SHC_RING) begin : g_ring
            for (genvar k = 0; k < N; k++) begin : g_line
                assign dec[k] = cur[N-1-k];
            end
        end else begin : g_twist
            localparam int BASE = (MODE == shc_pkg::SHC_TWIST_EVEN) ? N : N - 1;

            // empty chain
            assign dec[0] = ~cur[N-1] & ~cur[0];

            // ones filling in from the entry side: boundary after k ones
            for (genvar k = 1; k < N; k++) begin : g_fill
                assign dec[k] = cur[N-k] & ~cur[N-1-k];
            end

            // full chain exists only in the even variant
            if (MODE == shc_pkg::SHC_TWIST_EVEN) begin : g_full
                assign dec[N] = cur[N-1] & cur[0];
            end

            // zeros filling in from the entry side: boundary after j zeros
            for (genvar j = 1; j < N; j++) begin : g_drain
                assign dec[BASE+j] = ~cur[N-j] & cur[N-1-j];
            end
        end
    endgenerate
endmodule

// File: rtl/shift_counter.sv
module shift_counter #(
    parameter int                N    = 4,
    parameter shc_pkg::shc_mode_e MODE = shc_pkg::SHC_TWIST_EVEN,
    localparam int               NS   = shc_pkg::shc_state_count(MODE, N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_en,
    output logic [N-1:0]  stage_q,
    output logic [NS-1:0] dec_o
);
    localparam logic [N-1:0] SEED =
        (MODE == shc_pkg::SHC_RING) ? {1'b1, {(N-1){1'b0}}} : '0;

    typedef struct packed {
        logic [N-1:0] stage;
    } ctr_state_t;

    ctr_state_t   ctr_d;
    ctr_state_t   ctr_q;
    logic [N-1:0] shifted;
    logic         legal;

    shc_feedback #(.N(N), .MODE(MODE)) u_feedback (
        .cur (ctr_q.stage),
        .nxt (shifted)
    );

    shc_guard #(.N(N), .MODE(MODE)) u_guard (
        .cur   (ctr_q.stage),
        .legal (legal)
    );

    shc_decode #(.N(N), .MODE(MODE)) u_decode (
        .cur (ctr_q.stage),
        .dec (dec_o)
    );

    always_comb begin
        ctr_d = ctr_q;
        if (rst || !legal) begin
            ctr_d.stage = SEED;
        end else if (cnt_en) begin
            ctr_d.stage = shifted;
        end
    end

    always_ff @(posedge clk) begin
        ctr_q <= ctr_d;
    end

    assign stage_q = ctr_q.stage;
endmodule

// File: rtl/shc_checker.sv
module shc_checker #(
    parameter int                N    = 4,
    parameter shc_pkg::shc_mode_e MODE = shc_pkg::SHC_TWIST_EVEN,
    localparam int               NS   = shc_pkg::shc_state_count(MODE, N)
) (
    input logic          clk,
    input logic          rst,
    input logic          cnt_en,
    input logic [N-1:0]  stage,
    input logic [NS-1:0] dec
);
    localparam logic [N-1:0] SEED =
        (MODE == shc_pkg::SHC_RING) ? {1'b1, {(N-1){1'b0}}} : '0;

    logic legal;
    int   flips;

    always_comb begin
        flips = 0;
        for (int i = 0; i < N - 1; i++) begin
            if (stage[i] != stage[i+1]) flips++;
        end
        if (MODE == shc_pkg::SHC_RING) begin
            legal = ($countones(stage) == 1);
        end else if (MODE == shc_pkg::SHC_TWIST_ODD) begin
            legal = (flips <= 1) && (stage != '1);
        end else begin
            legal = (flips <= 1);
        end
    end

    // R2: first cycle after reset shows the seed pattern
    a_r2_reset_value: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && legal) |-> stage == SEED);

    // R6: the seed pattern lights decoded line 0
    a_r6_first_line: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && legal) |-> dec[0]);

    // R5: no advance while the enable is low
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && legal) |=> $stable(stage));

    // R7: one decoded line per legal state
    a_r7_dec_onehot: assert property (@(posedge clk) disable iff (rst)
        legal |-> $countones(dec) == 1);

    // R8: an illegal pattern is replaced by the seed on the next edge
    a_r8_recover: assert property (@(posedge clk) disable iff (rst)
        !legal |=> stage == SEED);

    generate
        if (MODE == shc_pkg::SHC_RING) begin : g_ring
            // R1: the single one moves down and wraps
            a_r1_ring_rotate: assert property (@(posedge clk) disable iff (rst)
                (cnt_en && legal) |=> stage == {$past(stage[0]), $past(stage[N-1:1])});
        end else if (MODE == shc_pkg::SHC_TWIST_EVEN) begin : g_even
            // R3: inverted last stage enters at the top
            a_r3_even_shift: assert property (@(posedge clk) disable iff (rst)
                (cnt_en && legal) |=> stage == {~$past(stage[0]), $past(stage[N-1:1])});
        end else begin : g_odd
            // R4: entry is the NOR of the two last stages
            a_r4_odd_shift: assert property (@(posedge clk) disable iff (rst)
                (cnt_en && legal) |=>
                    stage == {~$past(stage[1]) & ~$past(stage[0]), $past(stage[N-1:1])});
            // R4: all ones is never reached from a legal state
            a_r4_no_all_ones: assert property (@(posedge clk) disable iff (rst)
                legal |=> stage != '1);
        end
    endgenerate
endmodule

bind shift_counter shc_checker #(.N(N), .MODE(MODE)) u_shc_checker (
    .clk    (clk),
    .rst    (rst),
    .cnt_en (cnt_en),
    .stage  (stage_q),
    .dec    (dec_o)
);

// File: tb/shc_lane.sv
// One counter under test with its own driver, scoreboard queue and monitor.
module shc_lane #(
    parameter int                N    = 4,
    parameter shc_pkg::shc_mode_e MODE = shc_pkg::SHC_TWIST_EVEN
) (
    input  logic clk,
    output int   n_chk,
    output int   n_err,
    output logic done
);
    localparam int NS = shc_pkg::shc_state_count(MODE, N);
    localparam logic [N-1:0] SEED =
        (MODE == shc_pkg::SHC_RING) ? {1'b1, {(N-1){1'b0}}} : '0;

    typedef struct {
        logic [N-1:0]  stage;
        logic [NS-1:0] dec;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    logic          rst;
    logic          cnt_en;
    logic [N-1:0]  stage_q;
    logic [NS-1:0] dec_o;
    logic [N-1:0]  bad_pat;
    int            idx;

    shift_counter #(.N(N), .MODE(MODE)) uut (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .stage_q(stage_q),
        .dec_o  (dec_o)
    );

    // Pattern of state k, written from the sequence description (R1, R3, R4).
    function automatic logic [N-1:0] exp_stage(int k);
        logic [N-1:0] s;
        s = '0;
        for (int i = 0; i < N; i++) begin
            int p;
            p = N - 1 - i;  // distance from the entry stage
            if (MODE == shc_pkg::SHC_RING) begin
                s[i] = (p == k);
            end else if (MODE == shc_pkg::SHC_TWIST_EVEN) begin
                if (k >= 1 && k <= N) s[i] = (p < k);
                else if (k > N)       s[i] = (p >= k - N);
            end else begin
                if (k >= 1 && k <= N - 1) s[i] = (p < k);
                else if (k >= N)          s[i] = (p >= k - N + 1);
            end
        end
        return s;
    endfunction

    function automatic string seq_tag();
        if (MODE == shc_pkg::SHC_RING) return "R1";
        if (MODE == shc_pkg::SHC_TWIST_EVEN) return "R3";
        return "R4";
    endfunction

    task automatic push_exp(string tag);
        exp_t e;
        e.stage = exp_stage(idx);
        e.dec   = {{(NS-1){1'b0}}, 1'b1} << idx;
        e.tag   = tag;
        sb.push_back(e);
    endtask

    // Called at a falling edge; drives one cycle and queues the state after it.
    task automatic cyc(bit r, bit e, string tag);
        rst    = r;
        cnt_en = e;
        if (r)      idx = 0;
        else if (e) idx = (idx + 1) % NS;
        push_exp(tag);
        @(negedge clk);
    endtask

    // Reset, then overwrite the register with bad_pat; expect the seed back (R8).
    task automatic inject(bit e);
        cyc(1'b1, e, "R2");
        rst    = 1'b0;
        cnt_en = e;
        force uut.ctr_q = bad_pat;
        #1;
        release uut.ctr_q;
        idx = 0;
        push_exp("R8");
        @(negedge clk);
    endtask

    // driver
    initial begin
        rst    = 1'b1;
        cnt_en = 1'b0;
        idx    = 0;
        done   = 1'b0;
        bad_pat = '0;
        @(negedge clk);
        cyc(1'b1, 1'b0, "R2");
        cyc(1'b1, 1'b1, "R2");                       // reset wins over enable
        repeat (2 * NS + 1) cyc(1'b0, 1'b1, seq_tag());
        repeat (3) cyc(1'b0, 1'b0, "R5");
        for (int i = 0; i < 2 * NS; i++) cyc(1'b0, (i % 3) != 0, "R6");
        cyc(1'b1, 1'b1, "R2");
        repeat (2) cyc(1'b0, 1'b1, seq_tag());
        // ends set, middle clear: illegal in every mode
        bad_pat = '0;
        bad_pat[N-1] = 1'b1;
        bad_pat[0]   = 1'b1;
        inject(1'b1);
        cyc(1'b0, 1'b1, "R8");
        if (MODE == shc_pkg::SHC_RING) begin
            bad_pat = '0;
            inject(1'b0);
            bad_pat = '1;
            inject(1'b1);
        end else begin
            for (int i = 0; i < N; i++) bad_pat[i] = (i % 2) == 1;
            inject(1'b0);
            if (MODE == shc_pkg::SHC_TWIST_ODD) begin
                bad_pat = '1;
                inject(1'b1);
            end
        end
        repeat (3) cyc(1'b0, 1'b1, "R8");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    // monitor: one queued item per rising edge, sampled a quarter period later
    initial begin
        exp_t got;
        n_chk = 0;
        n_err = 0;
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                got = sb.pop_front();
                n_chk++;
                if (stage_q !== got.stage) begin
                    n_err++;
                    $display("FAIL %s N=%0d mode=%0d stage actual %b expected %b",
                             got.tag, N, int'(MODE), stage_q, got.stage);
                end
                n_chk++;
                if (dec_o !== got.dec) begin
                    n_err++;
                    $display("FAIL %s/R6 N=%0d mode=%0d dec actual %b expected %b",
                             got.tag, N, int'(MODE), dec_o, got.dec);
                end
                n_chk++;
                if ($countones(dec_o) != 1) begin
                    n_err++;
                    $display("FAIL R7 N=%0d mode=%0d high lines actual %0d expected 1",
                             N, int'(MODE), $countones(dec_o));
                end
                if (MODE == shc_pkg::SHC_TWIST_ODD) begin
                    n_chk++;
                    if (stage_q == '1) begin
                        n_err++;
                        $display("FAIL R4 N=%0d all-ones reached actual %b expected not %b",
                                 N, stage_q, {N{1'b1}});
                    end
                end
            end
        end
    end
endmodule

// File: tb/shift_counter_test.sv
module shift_counter_test;
    localparam int LANES    = 9;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    int             chk [LANES];
    int             err [LANES];
    logic [LANES-1:0] done;

    // stage counts 3, 4, 5 crossed with the three variants
    for (genvar gn = 0; gn < 3; gn++) begin : g_n
        for (genvar gm = 0; gm < 3; gm++) begin : g_m
            shc_lane #(
                .N    (gn + 3),
                .MODE (shc_pkg::shc_mode_e'(gm))
            ) u_lane (
                .clk   (clk),
                .n_chk (chk[gn*3+gm]),
                .n_err (err[gn*3+gm]),
                .done  (done[gn*3+gm])
            );
        end
    end

    initial begin
        int cycles;
        int total_chk;
        int total_err;
        cycles    = 0;
        total_chk = 0;
        total_err = 0;
        while (done !== '1 && cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        @(negedge clk);
        for (int i = 0; i < LANES; i++) begin
            total_chk += chk[i];
            total_err += err[i];
        end
        if (done !== '1) begin
            total_chk++;
            total_err++;
            $display("FAIL watchdog (R1 to R8 lanes) actual done=%b expected all set", done);
        end
        $display("CHECKS %0d ERRORS %0d", total_chk, total_err);
        $finish;
    end
endmodule